// File: doc/BRIEF.md
# Four-Mode Control Register

This block is a small clocked register, four bits wide by default. A two-bit mode input picks what happens to it at each rising clock edge. It can keep its value, flip every bit in place, clear itself to zero in step with the clock, or take a new parallel word.

Each stored bit is a D flip-flop fed by a four-way selector. The selector's inputs are the bit itself, its inverse, a constant zero and the matching data bit. The mode code drives the select lines of all the selectors together.

An asynchronous active-low reset forces the register to zero at power-up, whatever the mode. The mode and data are only looked at on the rising edge, so they may change freely between edges.

The block has no streaming path. Mode and data are plain level inputs, and the output is the stored word.

Top module: `quad_mode_reg`

## Requirements
- R1: While `rst_n` is low, `reg_q` is 0000, and it becomes 0000 without waiting for a clock edge.
- R2: With `mode_sel` = 2'b00 at a rising edge, `reg_q` keeps its previous value.
- R3: With `mode_sel` = 2'b01 at a rising edge, every bit of `reg_q` becomes the inverse of its previous value.
- R4: With `mode_sel` = 2'b10 at a rising edge, `reg_q` becomes 0000 at that edge, whatever its previous value and whatever `par_in` holds.
- R5: With `mode_sel` = 2'b11 at a rising edge, `reg_q` takes the value of `par_in` sampled at that edge.
- R6: The reset clears the register whatever value `mode_sel` holds.
- R7: `mode_sel` and `par_in` are sampled only at the rising edge. Changing them between edges leaves `reg_q` unchanged.
- R8: Two consecutive edges with `mode_sel` = 2'b01 return `reg_q` to the value it held before the first of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the register |
| mode_sel | input | 2 | 00 hold, 01 invert, 10 clear, 11 load |
| par_in | input | 4 | Parallel word taken in load mode |
| reg_q | output | 4 | Stored register contents |

## Verification
Every mode is applied from every one of the sixteen starting values, each time with every one of the sixteen data words on `par_in`. This separates the modes cleanly:
- Hold and invert are the only ones that depend on the old value.
- Load is the only one that follows the data.
- Clear must ignore both the old value and the data.

Inversion is also applied twice in a row from every value, to show that it returns the starting value. The reset is asserted between edges under each mode code, and it must clear the register before the next edge. Mode and data are also changed in mid-cycle, to show that the output moves only at an edge.

// File: rtl/quad_mode_reg_pkg.sv
package quad_mode_reg_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP  = 2'b00,
    MODE_FLIP  = 2'b01,
    MODE_ZERO  = 2'b10,
    MODE_LOAD  = 2'b11
  } reg_mode_e;
endpackage

// File: rtl/qmr_slice.sv
// One stored bit: a four-way selector in front of a D flip-flop.
module qmr_slice
  import quad_mode_reg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  reg_mode_e mode,
  input  logic      din,
  output logic      q
);
  logic nxt;

  always_comb begin
    unique case (mode)
      MODE_KEEP: nxt = q;
      MODE_FLIP: nxt = ~q;
      MODE_ZERO: nxt = 1'b0;
      MODE_LOAD: nxt = din;
      default:   nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/quad_mode_reg.sv
module quad_mode_reg
  import quad_mode_reg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] reg_q
);
  localparam int LAST = WIDTH - 1;

  reg_mode_e mode;
  assign mode = reg_mode_e'(mode_sel);

  for (genvar i = 0; i <= LAST; i++) begin : g_bit
    qmr_slice u_slice (
      .clk  (clk),
      .rst_n(rst_n),
      .mode (mode),
      .din  (par_in[i]),
      .q    (reg_q[i])
    );
  end
endmodule

// File: rtl/quad_mode_reg_chk.sv
module quad_mode_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_sel,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] reg_q
);
  // R1 R6
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (reg_q == '0));

  // R2
  keep_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |=> (reg_q == $past(reg_q)));

  // R3
  flip_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01) |=> (reg_q == ~$past(reg_q)));

  // R4
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10) |=> (reg_q == '0));

  // R5
  load_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |=> (reg_q == $past(par_in)));

  // R8
  double_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01) ##1 (mode_sel == 2'b01) |=> (reg_q == $past(reg_q, 2)));
endmodule

bind quad_mode_reg quad_mode_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .par_in(par_in), .reg_q(reg_q)
);

// File: tb/tb_quad_mode_reg.sv
`timescale 1ns/1ps
module tb_quad_mode_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [3:0] par_in = 4'h0;
  logic [3:0] reg_q;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  quad_mode_reg dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .par_in(par_in), .reg_q(reg_q)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic step(input logic [1:0] m, input logic [3:0] d);
    mode_sel = m;
    par_in   = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] model(input logic [1:0] m, input logic [3:0] old,
                                       input logic [3:0] d);
    case (m)
      2'b00:   return old;
      2'b01:   return 4'hF - old;
      2'b10:   return 4'h0;
      default: return d;
    endcase
  endfunction

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset state", reg_q, 4'h0);
    rst_n = 1'b1;

    // Main sweep over start value, mode and data: R2 R3 R4 R5
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 4; m++) begin
        for (int d = 0; d < 16; d++) begin
          step(2'b11, 4'(s));
          step(2'(m), 4'(d));
          case (m)
            0: check("R2 hold", reg_q, model(2'(m), 4'(s), 4'(d)));
            1: check("R3 invert", reg_q, model(2'(m), 4'(s), 4'(d)));
            2: check("R4 clear", reg_q, model(2'(m), 4'(s), 4'(d)));
            default: check("R5 load", reg_q, model(2'(m), 4'(s), 4'(d)));
          endcase
        end
      end
    end

    // R8: invert twice returns the start value
    for (int s = 0; s < 16; s++) begin
      step(2'b11, 4'(s));
      step(2'b01, 4'(15 - s));
      step(2'b01, 4'(s));
      check("R8 double invert", reg_q, 4'(s));
    end

    // R7: inputs changed between edges do not move the output
    for (int s = 0; s < 16; s++) begin
      step(2'b11, 4'(s));
      mode_sel = 2'b11; par_in = 4'(15 - s);
      #1;
      mode_sel = 2'b01;
      #1;
      mode_sel = 2'b10;
      #1;
      check("R7 no change between edges", reg_q, 4'(s));
      mode_sel = 2'b00;
      @(posedge clk);
      @(negedge clk);
      check("R7 hold after mid-cycle change", reg_q, 4'(s));
    end

    // R6 / R1: asynchronous reset under every mode code
    for (int m = 0; m < 4; m++) begin
      step(2'b11, 4'hB);
      mode_sel = 2'(m);
      par_in   = 4'h7;
      #1;
      rst_n = 1'b0;
      #1;
      check("R6 R1 async reset under mode", reg_q, 4'h0);
      @(posedge clk);
      @(negedge clk);
      check("R1 reset held across edge", reg_q, 4'h0);
      rst_n = 1'b1;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule